// File: doc/BRIEF.md
# Byte-Stream to GMII Transmit Framer

The framer takes outgoing Ethernet frames as a stream of bytes on an AXI4-Stream style handshake and turns each into a complete line frame on a byte-wide media interface with data, enable and error signals. Ahead of every frame it sends the preamble and start delimiter. It then forwards the frame bytes and fills any frame below the minimum size with zero bytes. It closes the frame with a CRC-32 check sequence computed over everything after the delimiter. It then holds the line idle for a gap whose length is set at run time.

A single clock runs the block. A clock-enable input marks the cycles on which the line advances, which lets the same logic serve lower line rates. A mode input selects nibble operation: each byte then takes two enabled cycles on the low four data lines. The upstream source sees `s_ready` only while frame bytes are being taken. It must hold `s_valid` through a frame, because the line cannot stall once the preamble has begun. A byte missing from the source in mid-frame is sent as an error byte.

Top module: `gmii_tx_framer`

## Requirements
- R1: While `rst` is high and afterwards until a frame is offered, `tx_en`, `tx_er` and `s_ready` are low.
- R2: Every frame begins on the line with seven 0x55 bytes followed by one 0xD5 byte, all with `tx_en` high, before the first input byte.
- R3: Input bytes appear on the line in the order given, one per byte step, and `s_ready` is high only on byte steps of the data phase.
- R4: With padding enabled, a frame of fewer than MIN_LEN-4 input bytes is extended with 0x00 bytes to exactly MIN_LEN-4 bytes. A longer frame is not extended. `tx_en` falls right after the check sequence.
- R5: Four check bytes follow the data and padding. They hold the complement of the reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over the data and padding bytes, least significant byte first.
- R6: After the last check byte, `tx_en` stays low for exactly `gap_len` byte steps when the next frame is already offered. A `gap_len` of 0 lets the next preamble follow at once.
- R7: On a cycle where `clk_en` is low, `tx_d`, `tx_en` and `tx_er` keep the values they had before that edge.
- R8: With `mii_mode` high, each byte takes two enabled cycles, the low nibble first, on `tx_d[3:0]`, with `tx_d[7:4]` zero and `tx_en` equal across both halves.
- R9: An input byte carrying both `s_last` and `s_user` is sent with `tx_er` and `tx_en` high and ends the frame with no padding or check bytes, followed by the normal gap. `tx_er` is low on all other bytes of a correctly fed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Line advance enable |
| mii_mode | input | 1 | 1 selects nibble operation |
| gap_len | input | GAP_W | Idle byte count between frames |
| s_data | input | 8 | Frame byte from the source |
| s_valid | input | 1 | Source byte valid |
| s_ready | output | 1 | Byte taken on this edge |
| s_last | input | 1 | Last byte of the frame |
| s_user | input | 1 | Abort marker, sampled with `s_last` |
| tx_d | output | 8 | Line data (nibble on bits 3:0 in nibble mode) |
| tx_en | output | 1 | Line data enable |
| tx_er | output | 1 | Line error |

## Verification
The hardest case to reach is the exact gap count when frames arrive back to back. If the source is late, the gap stretches and hides an off-by-one error. The stimulus therefore keeps the first byte of the next frame offered all through the current frame's check and gap phases. It does this at full rate, with the enable on only every third cycle, and in nibble mode. Frame lengths sweep from 1 to 66 bytes, so both sides of the padding boundary and the case that needs no padding all pass through the same gap measurement. An aborted frame is placed mid-sequence so that the gap after it is measured as well.

// File: rtl/gtx_pkg.sv
package gtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } tx_state_e;

  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
  localparam int          PRE_LAST  = 7;
  localparam int          FCS_BYTES = 4;
endpackage

// File: rtl/gtx_crc_step.sv
module gtx_crc_step
  import gtx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [31:0]   crc_i,
  input  logic [DW-1:0] data_i,
  output logic [31:0]   crc_o
);
  always_comb begin
    logic [31:0] c;
    c = crc_i;
    for (int b = 0; b < DW; b++) begin
      if (c[0] ^ data_i[b]) c = (c >> 1) ^ CRC_POLY;
      else                  c = c >> 1;
    end
    crc_o = c;
  end
endmodule

// File: rtl/gtx_rate_ctl.sv
module gtx_rate_ctl (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic mii_mode,
  output logic byte_step,
  output logic hi_step
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst)                      phase <= 1'b0;
    else if (!mii_mode)           phase <= 1'b0;
    else if (clk_en)              phase <= ~phase;
  end

  assign byte_step = clk_en && !(mii_mode && phase);
  assign hi_step   = clk_en && mii_mode && phase;

  // R8: in nibble mode two byte steps never fall on consecutive cycles
  a_r8_nibble_pairs: assert property (@(posedge clk) disable iff (rst)
    (mii_mode && byte_step) |=> !(byte_step && mii_mode));
endmodule

// File: rtl/gtx_framer_fsm.sv
module gtx_framer_fsm
  import gtx_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter bit PAD_EN  = 1'b1,
  parameter int CNT_W   = 16,
  parameter int GAP_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_step,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_last,
  input  logic             s_user,
  output logic [7:0]       nxt_byte,
  output logic             nxt_en,
  output logic             nxt_er
);
  localparam int DATA_MIN = MIN_LEN - FCS_BYTES;

  tx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [GAP_W-1:0] gcnt;
  logic [GAP_W-1:0] gcnt_inc;
  logic [31:0]      crc;
  logic [31:0]      crc_nx;
  logic [31:0]      fcs;
  logic             take;
  logic             short_frame;

  assign cnt_inc     = cnt + 1'b1;
  assign gcnt_inc    = gcnt + 1'b1;
  assign fcs         = ~crc;
  assign take        = (state == ST_DATA) && s_valid;
  assign s_ready     = (state == ST_DATA) && byte_step;
  assign short_frame = PAD_EN && (cnt_inc < CNT_W'(DATA_MIN));

  gtx_crc_step #(.DW(8)) u_crc (
    .crc_i  (crc),
    .data_i (nxt_byte),
    .crc_o  (crc_nx)
  );

  always_comb begin
    nxt_byte = 8'h00;
    nxt_en   = 1'b0;
    nxt_er   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (s_valid) begin
          nxt_byte = PRE_BYTE;
          nxt_en   = 1'b1;
        end
      end
      ST_PRE: begin
        nxt_en   = 1'b1;
        nxt_byte = (cnt == CNT_W'(PRE_LAST)) ? SFD_BYTE : PRE_BYTE;
      end
      ST_DATA: begin
        nxt_en = 1'b1;
        if (s_valid) begin
          nxt_byte = s_data;
          nxt_er   = s_last && s_user;
        end else begin
          nxt_er   = 1'b1;
        end
      end
      ST_PAD: begin
        nxt_en = 1'b1;
      end
      ST_FCS: begin
        nxt_en = 1'b1;
        unique case (cnt[1:0])
          2'd0: nxt_byte = fcs[7:0];
          2'd1: nxt_byte = fcs[15:8];
          2'd2: nxt_byte = fcs[23:16];
          default: nxt_byte = fcs[31:24];
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      gcnt  <= '0;
      crc   <= CRC_SEED;
    end else if (byte_step) begin
      unique case (state)
        ST_IDLE: begin
          if (s_valid) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(1);
          end
        end
        ST_PRE: begin
          if (cnt == CNT_W'(PRE_LAST)) begin
            state <= ST_DATA;
            cnt   <= '0;
            crc   <= CRC_SEED;
          end else begin
            cnt <= cnt_inc;
          end
        end
        ST_DATA: begin
          if (take) begin
            crc <= crc_nx;
            cnt <= cnt_inc;
            if (s_last) begin
              if (s_user) begin
                state <= (gap_len == '0) ? ST_IDLE : ST_GAP;
                gcnt  <= '0;
              end else if (short_frame) begin
                state <= ST_PAD;
              end else begin
                state <= ST_FCS;
                cnt   <= '0;
              end
            end
          end
        end
        ST_PAD: begin
          crc <= crc_nx;
          if (cnt_inc == CNT_W'(DATA_MIN)) begin
            state <= ST_FCS;
            cnt   <= '0;
          end else begin
            cnt <= cnt_inc;
          end
        end
        ST_FCS: begin
          if (cnt == CNT_W'(FCS_BYTES - 1)) begin
            state <= (gap_len == '0) ? ST_IDLE : ST_GAP;
            gcnt  <= '0;
          end else begin
            cnt <= cnt_inc;
          end
        end
        default: begin
          gcnt <= gcnt_inc;
          if (gcnt_inc >= gap_len) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R2: the data phase is entered only from the last preamble byte
  a_r2_data_after_sfd: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) != ST_DATA) |->
      ($past(state) == ST_PRE && $past(cnt) == CNT_W'(PRE_LAST)));

  // R4: padding hands over to the check bytes only at the minimum length
  a_r4_pad_to_min: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FCS && $past(state) == ST_PAD) |->
      ($past(cnt) == CNT_W'(DATA_MIN - 1)));
endmodule

// File: rtl/gmii_tx_framer.sv
module gmii_tx_framer
  import gtx_pkg::*;
#(
  parameter int MIN_LEN = 64,
  parameter bit PAD_EN  = 1'b1,
  parameter int CNT_W   = 16,
  parameter int GAP_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             mii_mode,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_last,
  input  logic             s_user,
  output logic [7:0]       tx_d,
  output logic             tx_en,
  output logic             tx_er
);
  logic       byte_step;
  logic       hi_step;
  logic [7:0] nxt_byte;
  logic       nxt_en;
  logic       nxt_er;
  logic [3:0] hi_nib;

  gtx_rate_ctl u_rate (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .mii_mode  (mii_mode),
    .byte_step (byte_step),
    .hi_step   (hi_step)
  );

  gtx_framer_fsm #(
    .MIN_LEN (MIN_LEN),
    .PAD_EN  (PAD_EN),
    .CNT_W   (CNT_W),
    .GAP_W   (GAP_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .byte_step (byte_step),
    .gap_len   (gap_len),
    .s_data    (s_data),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_last    (s_last),
    .s_user    (s_user),
    .nxt_byte  (nxt_byte),
    .nxt_en    (nxt_en),
    .nxt_er    (nxt_er)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d   <= '0;
      tx_en  <= 1'b0;
      tx_er  <= 1'b0;
      hi_nib <= '0;
    end else if (byte_step) begin
      tx_d   <= mii_mode ? {4'h0, nxt_byte[3:0]} : nxt_byte;
      hi_nib <= nxt_byte[7:4];
      tx_en  <= nxt_en;
      tx_er  <= nxt_er;
    end else if (hi_step) begin
      tx_d <= {4'h0, hi_nib};
    end
  end

  // R7: nothing on the line moves without the enable
  a_r7_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(tx_d) && $stable(tx_en) && $stable(tx_er)));

  // R9: an error byte is always inside a frame
  a_r9_error_inside_frame: assert property (@(posedge clk) disable iff (rst)
    tx_er |-> tx_en);
endmodule

// File: tb/gmii_tx_framer_tb.sv
`timescale 1ns/1ps
module gmii_tx_framer_tb;
  localparam int MIN_LEN  = 64;
  localparam int DATA_MIN = MIN_LEN - 4;
  localparam int MAXR     = 16000;
  localparam int MAXF     = 80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clk_en = 1'b0;
  logic       mii_mode = 1'b0;
  logic [7:0] gap_len = 8'd12;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic       s_last = 1'b0;
  logic       s_user = 1'b0;
  logic [7:0] tx_d;
  logic       tx_en;
  logic       tx_er;

  gmii_tx_framer #(.MIN_LEN(MIN_LEN)) u_dut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .mii_mode(mii_mode),
    .gap_len(gap_len), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .s_last(s_last), .s_user(s_user), .tx_d(tx_d), .tx_en(tx_en), .tx_er(tx_er)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] rd [0:MAXR-1];
  logic       ren[0:MAXR-1];
  logic       rer[0:MAXR-1];
  int         rn = 0;
  logic [7:0] bd [0:MAXR-1];
  logic       be [0:MAXR-1];
  logic       br [0:MAXR-1];
  int         flen[0:MAXF-1];
  bit         ferr[0:MAXF-1];
  int         nf = 0;

  int   rate = 1;
  int   divcnt = 0;
  logic rst_seen = 1'b1;
  logic have_prev = 1'b0;
  logic [7:0] p_d;
  logic p_en, p_er;
  int   hold_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // enable generation, hold check (R7) and line recording share one edge
  always @(negedge clk) begin
    if (!rst_seen && have_prev && !clk_en)
      if (tx_d !== p_d || tx_en !== p_en || tx_er !== p_er) hold_bad++;
    if (!rst_seen && clk_en && rn < MAXR) begin
      rd[rn]  = tx_d;
      ren[rn] = tx_en;
      rer[rn] = tx_er;
      rn++;
    end
    p_d = tx_d; p_en = tx_en; p_er = tx_er;
    have_prev = !rst;
    rst_seen  = rst;
    clk_en <= (divcnt == 0);
    divcnt = (divcnt >= rate - 1) ? 0 : divcnt + 1;
  end

  function automatic logic [7:0] pay(input int k, input int i);
    return 8'((k * 31) + (i * 7) + 3);
  endfunction

  function automatic logic [31:0] crc_add(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] x;
    x = c ^ {24'h0, b};
    for (int j = 0; j < 8; j++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
    return x;
  endfunction

  task automatic add_frame(input int n, input bit err);
    flen[nf] = n;
    ferr[nf] = err;
    nf++;
  endtask

  task automatic send_all();
    for (int k = 0; k < nf; k++) begin
      for (int i = 0; i < flen[k]; i++) begin
        bit hs;
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = pay(k, i);
        s_last  = (i == flen[k] - 1);
        s_user  = ferr[k] && (i == flen[k] - 1);
        hs = 1'b0;
        while (!hs) begin
          #4;
          hs = s_ready;
          @(posedge clk);
          if (!hs) @(negedge clk);
        end
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    s_user  = 1'b0;
  endtask

  task automatic analyze(input string tag);
    int nb, p, bad8;
    nb = 0;
    bad8 = 0;
    if (mii_mode) begin
      for (int j = 0; j + 1 < rn; j += 2) begin
        if (ren[j] !== ren[j+1] || rd[j][7:4] !== 4'h0 || rd[j+1][7:4] !== 4'h0)
          bad8++;
        bd[nb] = {rd[j+1][3:0], rd[j][3:0]};
        be[nb] = ren[j];
        br[nb] = rer[j];
        nb++;
      end
      chk(bad8 == 0, "R8", {tag, " nibble pairing"}, bad8, 0);
    end else begin
      for (int j = 0; j < rn; j++) begin
        bd[j] = rd[j]; be[j] = ren[j]; br[j] = rer[j];
      end
      nb = rn;
    end
    p = 0;
    for (int k = 0; k < nf; k++) begin
      int idle, pre_bad, n, padto, body, dbad, pbad, fbad, ebad;
      logic [31:0] c;
      idle = 0;
      while (p < nb && !be[p]) begin idle++; p++; end
      if (k > 0) chk(idle == int'(gap_len), "R6", {tag, " gap"}, idle, int'(gap_len));
      pre_bad = 0;
      for (int i = 0; i < 8; i++) begin
        if (p >= nb || !be[p] || bd[p] !== ((i == 7) ? 8'hD5 : 8'h55)) pre_bad++;
        p++;
      end
      chk(pre_bad == 0, "R2", {tag, " preamble"}, pre_bad, 0);
      n = flen[k];
      padto = (n < DATA_MIN) ? DATA_MIN : n;
      body = ferr[k] ? n : padto + 4;
      c = 32'hFFFFFFFF;
      dbad = 0; pbad = 0; fbad = 0; ebad = 0;
      for (int i = 0; i < body; i++) begin
        logic [7:0] ex;
        logic [31:0] f;
        f = ~c;
        if (i < n) ex = pay(k, i);
        else if (i < padto) ex = 8'h00;
        else ex = 8'(f >> (8 * (i - padto)));
        if (i < padto) c = crc_add(c, ex);
        if (p >= nb || !be[p] || bd[p] !== ex) begin
          if (i < n) dbad++;
          else if (i < padto) pbad++;
          else fbad++;
        end
        if (p < nb && br[p] !== (ferr[k] && i == n - 1)) ebad++;
        p++;
      end
      chk(dbad == 0, "R3", {tag, " data bytes"}, dbad, 0);
      if (!ferr[k]) begin
        bit endok;
        endok = 1'b1;
        if (gap_len != 0 || k == nf - 1) endok = (p < nb) && !be[p];
        chk(pbad == 0 && endok, "R4", {tag, " padding/length"}, pbad + (endok ? 0 : 1000), 0);
        chk(fbad == 0, "R5", {tag, " check bytes"}, fbad, 0);
      end else begin
        bit endok;
        endok = 1'b1;
        if (gap_len != 0 || k == nf - 1) endok = (p < nb) && !be[p];
        chk(endok, "R9", {tag, " abort ends frame"}, endok, 1);
      end
      chk(ebad == 0, "R9", {tag, " error marking"}, ebad, 0);
    end
  endtask

  task automatic run_seg(input string tag, input bit mii, input int r, input int g);
    @(posedge clk);
    #1;
    rst = 1'b1;
    mii_mode = mii;
    rate = r;
    gap_len = 8'(g);
    divcnt = 0;
    repeat (3) @(posedge clk);
    rn = 0;
    hold_bad = 0;
    #1;
    rst = 1'b0;
    @(negedge clk);
    #2;
    chk(!tx_en && !tx_er && !s_ready, "R1", {tag, " reset state"},
        {tx_en, tx_er, s_ready}, 0);
    send_all();
    repeat (200 * r * (mii ? 2 : 1)) @(posedge clk);
    analyze(tag);
    if (r > 1) chk(hold_bad == 0, "R7", {tag, " hold without enable"}, hold_bad, 0);
  endtask

  initial begin
    // full rate, byte mode, sweep across the padding boundary, abort mid-run
    nf = 0;
    for (int n = 1; n <= 66; n++) begin
      add_frame(n, 1'b0);
      if (n == 33) add_frame(9, 1'b1);
    end
    run_seg("byte/full", 1'b0, 1, 12);
    // slow enable, back to back frames
    nf = 0;
    add_frame(1, 1'b0); add_frame(46, 1'b0); add_frame(5, 1'b1);
    add_frame(60, 1'b0); add_frame(61, 1'b0); add_frame(70, 1'b0);
    run_seg("byte/third", 1'b0, 3, 0);
    // nibble mode at full rate
    nf = 0;
    add_frame(1, 1'b0); add_frame(45, 1'b0); add_frame(3, 1'b1);
    add_frame(60, 1'b0); add_frame(64, 1'b0);
    run_seg("nibble/full", 1'b1, 1, 5);
    // nibble mode with a divided enable
    nf = 0;
    add_frame(20, 1'b0); add_frame(61, 1'b0);
    run_seg("nibble/half", 1'b1, 2, 12);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule